// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Radio-State Patterns

This block drives the general-purpose pins of a radio daughterboard. The pins form two banks: pins 0 to 15 belong to the receive side and pins 16 to 31 to the transmit side. Every register word follows that split, with the transmit half in the upper 16 bits. Each pin has a direction bit that gates its output enable. It also has a 2-bit source code. The code picks what the pin drives: the software output word, a pattern word that tracks what the radio is doing, or one of two debug buses.

The radio reports its activity on two live status inputs, `tx_active` and `rx_active`. Four pattern registers cover the four possible activity states. The register that matches the current state drives every pin whose source code selects the pattern logic, so the pins follow the radio without any software action. Pads are modelled as three separate vectors: drive value, output enable and sampled input. Software reads the pin levels back through a two-stage synchronizer.

The register port is plain control. A write takes effect on the clock edge at which `wr_en` is high. Readback is combinational from `rd_addr`. Neither port has back-pressure: each write is accepted in the cycle it is presented.

Top module: `gpio_atr_bank`

## Requirements
- R1: After reset every register reads zero, `pad_oe` is all zero and `pad_out` is all zero (every pin uses source code 0 and the software word is zero).
- R2: `pad_oe[i]` equals bit i of the direction register (offset 1), whatever the pin's source code.
- R3: A pin with source code 0 drives bit i of the software output register (offset 0).
- R4: A pin with source code 1 drives bit i of the pattern register chosen by `{tx_active, rx_active}`. The choices are: 00 gives offset 4 (idle), 10 gives offset 5 (transmit only), 01 gives offset 6 (receive only) and 11 gives offset 7 (both). The change is combinational.
- R5: A pin with source code 2 drives `dbg0[i]`; a pin with source code 3 drives `dbg1[i]`.
- R6: Offset 2 holds the source codes of pins 16 to 31, with pin 16+k in bits [2k+1:2k]. Offset 3 holds the codes of pins 0 to 15, with pin k in bits [2k+1:2k].
- R7: Reading offset 0 returns `pad_in` delayed by two clock edges. After one edge the old value is still returned.
- R8: Reading offsets 1 to 7 returns the value last written to that offset. A write is visible from the clock edge at which `wr_en` was high.
- R9: Writing the software output register (offset 0) leaves the value read back at offset 0 unchanged, because that read reflects the pins only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_active | input | 1 | Live transmit-activity status |
| rx_active | input | 1 | Live receive-activity status |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word offset |
| rd_data | output | 32 | Register read data |
| dbg0 | input | 32 | Debug bus 0 (source code 2) |
| dbg1 | input | 32 | Debug bus 1 (source code 3) |
| pad_in | input | 32 | Sampled pad levels |
| pad_out | output | 32 | Pad drive values |
| pad_oe | output | 32 | Pad output enables |

## Verification
A wrong stored word shows at the ports in the same cycle as the readback of its offset, and on `pad_out` as soon as a pin selects it. A misrouted source code or pattern slot changes `pad_out` combinationally, so each check compares the whole 32-bit drive vector against a bench model right after the inputs settle. A synchronizer of the wrong depth shows as the pin readback changing one edge early or late. The bench therefore samples it after exactly one edge and after exactly two.

// File: rtl/gab_pkg.sv
package gab_pkg;
  typedef enum logic [1:0] {
    SRC_SW   = 2'd0,
    SRC_ATR  = 2'd1,
    SRC_DBG0 = 2'd2,
    SRC_DBG1 = 2'd3
  } pin_src_e;

  localparam int unsigned ADDR_W = 3;

  // pattern slot = address - 4 : idle 0, tx-only 1, rx-only 2, both 3
  function automatic logic [1:0] atr_slot(input logic tx, input logic rx);
    return {rx, tx};
  endfunction
endpackage

// File: rtl/gab_sync.sv
module gab_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

  // R7
  sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n)) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gab_regfile.sv
module gab_regfile
  import gab_pkg::*;
#(
  parameter int unsigned PINS = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [PINS-1:0]          wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [PINS-1:0]          pins_sync,
  output logic [PINS-1:0]          rd_data,
  output logic [PINS-1:0]          sw_q,
  output logic [PINS-1:0]          dir_q,
  output logic [PINS-1:0]          sel_hi_q,
  output logic [PINS-1:0]          sel_lo_q,
  output logic [3:0][PINS-1:0]     pat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q     <= '0;
      dir_q    <= '0;
      sel_hi_q <= '0;
      sel_lo_q <= '0;
      pat_q    <= '0;
    end else if (wr_en) begin
      if (wr_addr[2]) begin
        pat_q[wr_addr[1:0]] <= wr_data;
      end else begin
        unique case (wr_addr[1:0])
          2'd0: sw_q     <= wr_data;
          2'd1: dir_q    <= wr_data;
          2'd2: sel_hi_q <= wr_data;
          2'd3: sel_lo_q <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    if (rd_addr[2]) begin
      rd_data = pat_q[rd_addr[1:0]];
    end else begin
      unique case (rd_addr[1:0])
        2'd0:    rd_data = pins_sync;
        2'd1:    rd_data = dir_q;
        2'd2:    rd_data = sel_hi_q;
        default: rd_data = sel_lo_q;
      endcase
    end
  end

  // R8
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd1) |=> (dir_q == $past(wr_data)));

  // R6
  sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd2) |=> (sel_hi_q == $past(wr_data)));

  // R8
  pat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || !wr_addr[2]) |=> $stable(pat_q));
endmodule

// File: rtl/gab_pinmux.sv
module gab_pinmux
  import gab_pkg::*;
#(
  parameter int unsigned BANK_W = 16
) (
  input  logic [2*BANK_W-1:0] dir_q,
  input  logic [2*BANK_W-1:0] sw_q,
  input  logic [2*BANK_W-1:0] sel_hi_q,
  input  logic [2*BANK_W-1:0] sel_lo_q,
  input  logic [2*BANK_W-1:0] pat_word,
  input  logic [2*BANK_W-1:0] dbg0,
  input  logic [2*BANK_W-1:0] dbg1,
  output logic [2*BANK_W-1:0] pad_out,
  output logic [2*BANK_W-1:0] pad_oe
);
  localparam int unsigned PINS = 2 * BANK_W;

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic [1:0] code;
    logic       drive;
    if (p >= BANK_W) begin : g_hi
      assign code = sel_hi_q[2*(p-BANK_W) +: 2];
    end else begin : g_lo
      assign code = sel_lo_q[2*p +: 2];
    end
    always_comb begin
      unique case (pin_src_e'(code))
        SRC_SW:   drive = sw_q[p];
        SRC_ATR:  drive = pat_word[p];
        SRC_DBG0: drive = dbg0[p];
        default:  drive = dbg1[p];
      endcase
    end
    assign pad_out[p] = drive;
    assign pad_oe[p]  = dir_q[p];
  end
endmodule

// File: rtl/gpio_atr_bank.sv
module gpio_atr_bank
  import gab_pkg::*;
#(
  parameter int unsigned BANK_W = 16,
  localparam int unsigned PINS = 2 * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_active,
  input  logic              rx_active,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [PINS-1:0]   wr_data,
  input  logic [2:0]        rd_addr,
  output logic [PINS-1:0]   rd_data,
  input  logic [PINS-1:0]   dbg0,
  input  logic [PINS-1:0]   dbg1,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);
  logic [PINS-1:0]      pins_sync;
  logic [PINS-1:0]      sw_q, dir_q, sel_hi_q, sel_lo_q;
  logic [3:0][PINS-1:0] pat_q;
  logic [PINS-1:0]      pat_word;

  gab_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pins_sync)
  );

  gab_regfile #(.PINS(PINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .pins_sync(pins_sync), .rd_data(rd_data),
    .sw_q(sw_q), .dir_q(dir_q), .sel_hi_q(sel_hi_q), .sel_lo_q(sel_lo_q),
    .pat_q(pat_q)
  );

  assign pat_word = pat_q[atr_slot(tx_active, rx_active)];

  gab_pinmux #(.BANK_W(BANK_W)) u_mux (
    .dir_q(dir_q), .sw_q(sw_q), .sel_hi_q(sel_hi_q), .sel_lo_q(sel_lo_q),
    .pat_word(pat_word), .dbg0(dbg0), .dbg1(dbg1),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // R2
  oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir_q) == '0);
endmodule

// File: tb/tb_gpio_atr_bank.sv
`timescale 1ns/1ps
module tb_gpio_atr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_active = 1'b0, rx_active = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, dbg0 = '0, dbg1 = '0, pad_in = '0;
  logic [31:0] rd_data, pad_out, pad_oe;

  int n_tests = 0, n_fail = 0;
  logic [31:0] m_sw = '0, m_dir = '0, m_hi = '0, m_lo = '0;
  logic [31:0] m_pat [4];

  always #4 clk = ~clk;

  gpio_atr_bank dut (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .rx_active(rx_active),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .dbg0(dbg0), .dbg1(dbg1),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // offset 4 idle, 5 tx-only, 6 rx-only, 7 both
  function automatic logic [31:0] exp_pat();
    if (tx_active && rx_active) return m_pat[3];
    if (tx_active)              return m_pat[1];
    if (rx_active)              return m_pat[2];
    return m_pat[0];
  endfunction

  function automatic logic [31:0] exp_out();
    logic [31:0] r, pw;
    pw = exp_pat();
    for (int i = 0; i < 32; i++) begin
      logic [1:0] c;
      c = (i >= 16) ? m_hi[2*(i-16) +: 2] : m_lo[2*i +: 2];
      case (c)
        2'd0: r[i] = m_sw[i];
        2'd1: r[i] = pw[i];
        2'd2: r[i] = dbg0[i];
        default: r[i] = dbg1[i];
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_reg(input logic [2:0] a);
    case (a)
      3'd1: return m_dir;
      3'd2: return m_hi;
      3'd3: return m_lo;
      3'd4: return m_pat[0];
      3'd5: return m_pat[1];
      3'd6: return m_pat[2];
      3'd7: return m_pat[3];
      default: return 32'h0;
    endcase
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    case (a)
      3'd0: m_sw = d;
      3'd1: m_dir = d;
      3'd2: m_hi = d;
      3'd3: m_lo = d;
      default: m_pat[a - 3'd4] = d;
    endcase
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] seed_v;
    seed_v = $urandom(32'd4242);
    for (int k = 0; k < 4; k++) m_pat[k] = '0;
    dbg0 = 32'hFFFF_0F0F; dbg1 = 32'h1234_5678; pad_in = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 oe", pad_oe, 32'h0);
    chk("R1 out", pad_out, 32'h0);
    for (int a = 1; a < 8; a++) begin
      rd_addr = 3'(a); #1;
      chk("R1 reg", rd_data, 32'h0);
    end

    // R2 / R3 directed
    wr(3'd1, 32'h0000_FFFF);
    wr(3'd0, 32'hA5A5_5A5A);
    #1;
    chk("R2 oe", pad_oe, 32'h0000_FFFF);
    chk("R3 sw", pad_out, 32'hA5A5_5A5A);

    // R9: software word does not appear in pin readback
    rd_addr = 3'd0; #1;
    chk("R9 pins", rd_data, 32'h0);

    // R4 / R6: pin 0 and pin 16 on pattern, pin1 dbg0, pin2 dbg1
    wr(3'd3, 32'h0000_0039);
    wr(3'd2, 32'h0000_0001);
    wr(3'd4, 32'h0000_0000);
    wr(3'd5, 32'h0001_0000);
    wr(3'd6, 32'h0000_0001);
    wr(3'd7, 32'h0001_0001);
    for (int s = 0; s < 4; s++) begin
      tx_active = s[1]; rx_active = s[0]; #1;
      chk("R4 pattern", pad_out, exp_out());
      chk("R6 pin16", {31'h0, pad_out[16]}, {31'h0, exp_pat() >> 16} & 32'h1);
    end
    // R5 debug sources
    dbg0 = 32'h0000_0002; dbg1 = 32'h0000_0000; #1;
    chk("R5 dbg0", pad_out, exp_out());
    dbg0 = 32'h0; dbg1 = 32'h0000_0004; #1;
    chk("R5 dbg1", pad_out, exp_out());

    // R7 synchronizer depth
    @(negedge clk);
    pad_in = 32'hC3C3_3C3C; rd_addr = 3'd0;
    @(negedge clk); #1;
    chk("R7 one edge", rd_data, 32'h0);
    @(negedge clk); #1;
    chk("R7 two edges", rd_data, 32'hC3C3_3C3C);
    wr(3'd0, 32'h0F0F_F0F0);
    #1;
    chk("R9 pins after sw write", rd_data, 32'hC3C3_3C3C);

    // R8 readback of every stored offset
    for (int a = 1; a < 8; a++) begin
      rd_addr = 3'(a); #1;
      chk("R8 readback", rd_data, exp_reg(3'(a)));
    end

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [2:0]  a;
      logic [31:0] d;
      @(negedge clk);
      a = 3'($urandom_range(0, 7));
      d = $urandom();
      tx_active = 1'($urandom()); rx_active = 1'($urandom());
      dbg0 = $urandom(); dbg1 = $urandom();
      if ($urandom_range(0, 3) != 0) wr(a, d);
      else begin @(posedge clk); #1; end
      #1;
      chk("R2 rand oe", pad_oe, m_dir);
      chk("R5 rand out", pad_out, exp_out());
      rd_addr = 3'($urandom_range(1, 7)); #1;
      chk("R8 rand read", rd_data, exp_reg(rd_addr));
    end
    summary();
  end
endmodule